// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block owns the fetch address of a 32-bit load/store core whose architecture executes exactly one instruction after every control transfer. It holds the address of the instruction being fetched, which is always the slot that follows the instruction now being executed. Each cycle it decodes that executing instruction together with its two source operand values and picks the following fetch address. The choices are the sequential address, a PC-relative branch target, a region-relative jump target, or a register target. For the linking jumps it also raises a request to write the return address into the register file.

Every offset and every link value is taken from the slot address, not from the address of the control instruction. After reset the unit spends one cycle prefetching from the reset vector, which lies in an uncached high segment. The instruction input is ignored during that cycle. A stall input freezes all progress.

Top module: `dslot_npc`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `fetch_pc` equals 0xBFC00000 and `link_we` is 0.
- R2: The first unstalled cycle after reset is a prefetch. The instruction input is ignored, so `link_we` stays 0 even for a linking jump, and `fetch_pc` becomes 0xBFC00004.
- R3: With opcode field instr[31:26] equal to 2 (jump) or 3 (jump-and-link), the next `fetch_pc` is the top four bits of the current `fetch_pc`, followed by instr[25:0], followed by two zero bits.
- R4: Opcode 3 requests a link write to register 31 with the value `fetch_pc`+4.
- R5: Opcodes 4 (branch if equal) and 5 (branch if not equal) compare `rs_val` with `rt_val`. When taken, the next `fetch_pc` is `fetch_pc` plus the sign-extended instr[15:0] multiplied by 4.
- R6: Opcodes 6 (branch if ≤ 0) and 7 (branch if > 0) treat `rs_val` as a signed 32-bit number and use the offset rule of R5.
- R7: With opcode 0, funct field instr[5:0] equal to 8 jumps to `rs_val`. Funct 9 also jumps to `rs_val` and requests a link write of `fetch_pc`+4 to the register named by instr[15:11].
- R8: Any other instruction, and any branch that is not taken, gives a next `fetch_pc` of `fetch_pc`+4.
- R9: A link request whose target register is 0 is dropped, so `link_we` stays 0.
- R10: While `stall` is high, `fetch_pc` holds its value and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the unit for this cycle |
| instr | input | 32 | Instruction now executing |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| fetch_pc | output | 32 | Address being fetched (the delay slot of `instr`) |
| link_we | output | 1 | Link write request, valid in the same cycle |
| link_idx | output | 5 | Register to receive the return address |
| link_val | output | 32 | Return address |

## Verification
The bench builds the unit with its default reset vector 0xBFC00000 and link register 31. Because of that high vector, jump targets keep a nonzero region nibble taken from the slot. Backward branches from the reset region can move the address downwards, and register jumps can move it into other regions, after which later region-relative jumps must take the new top bits. Random operands are biased toward equality, zero and the sign boundary, so both outcomes of every compare are exercised. Extreme immediates test the full reach of the offset in both directions.

// File: rtl/dslot_npc.sv
module dslot_npc #(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000,
  parameter int          LINK_REG  = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] fetch_pc,
  output logic        link_we,
  output logic [4:0]  link_idx,
  output logic [31:0] link_val
);
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_J    = 6'd2;
  localparam logic [5:0] OP_JAL  = 6'd3;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_BLEZ = 6'd6;
  localparam logic [5:0] OP_BGTZ = 6'd7;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_JALR = 6'd9;
  localparam logic [4:0] LINK_IDX = 5'(LINK_REG);

  logic        booted_q;
  logic [31:0] pc_q;
  logic [31:0] seq_pc, br_pc, jmp_pc, npc;
  logic [5:0]  op, fn;
  logic        is_jal, is_jalr, rs_eq, rs_lez;
  logic [4:0]  raw_idx;
  logic        unused_bits;

  assign op      = instr[31:26];
  assign fn      = instr[5:0];
  assign unused_bits = ^instr[10:6];

  assign seq_pc  = pc_q + 32'd4;
  assign br_pc   = pc_q + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_pc  = {pc_q[31:28], instr[25:0], 2'b00};
  assign rs_eq   = (rs_val == rt_val);
  assign rs_lez  = ($signed(rs_val) <= 32'sd0);

  assign is_jal  = (op == OP_JAL);
  assign is_jalr = (op == OP_REG) && (fn == FN_JALR);

  always_comb begin
    npc = seq_pc;
    case (op)
      OP_J, OP_JAL: npc = jmp_pc;
      OP_BEQ:       if (rs_eq)   npc = br_pc;
      OP_BNE:       if (!rs_eq)  npc = br_pc;
      OP_BLEZ:      if (rs_lez)  npc = br_pc;
      OP_BGTZ:      if (!rs_lez) npc = br_pc;
      OP_REG:       if (fn == FN_JR || fn == FN_JALR) npc = rs_val;
      default:      npc = seq_pc;
    endcase
  end

  assign raw_idx  = is_jal ? LINK_IDX : instr[15:11];
  assign link_idx = raw_idx;
  assign link_val = seq_pc;
  assign link_we  = booted_q && !stall && (is_jal || is_jalr) && (raw_idx != 5'd0);
  assign fetch_pc = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      booted_q <= 1'b0;
    end else if (!stall) begin
      booted_q <= 1'b1;
      pc_q     <= booted_q ? npc : seq_pc;
    end
  end
endmodule

module dslot_npc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        booted,
  input logic [31:0] instr,
  input logic [31:0] fetch_pc,
  input logic        link_we,
  input logic [4:0]  link_idx,
  input logic [31:0] link_val
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_pc));
  // R10
  stall_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !link_we);
  // R9
  no_zero_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_idx != 5'd0);
  // R4
  link_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_val == fetch_pc + 32'd4);
  // R2
  boot_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !booted |-> !link_we);
  // R3
  jump_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (booted && !stall && instr[31:27] == 5'b00001) |=> fetch_pc[31:28] == $past(fetch_pc[31:28]));
  // R8
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (booted && !stall && instr[31:29] != 3'b000) |=> fetch_pc == $past(fetch_pc) + 32'd4);
endmodule

bind dslot_npc dslot_npc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .booted(booted_q), .instr(instr),
  .fetch_pc(fetch_pc), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
);

// File: tb/dslot_npc_bench.sv
module dslot_npc_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] RVEC = 32'hBFC0_0000;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic [31:0] instr = 32'd0, rs_val = 32'd0, rt_val = 32'd0;
  logic [31:0] fetch_pc, link_val;
  logic        link_we;
  logic [4:0]  link_idx;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mpc;

  always #(PERIOD/2) clk = ~clk;

  dslot_npc u_dslot_npc (.clk(clk), .rst_n(rst_n), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .fetch_pc(fetch_pc), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val));

  function automatic logic [31:0] exp_next(logic [31:0] i, logic [31:0] a, logic [31:0] b, logic [31:0] pc);
    logic [31:0] off;
    logic take;
    off = {{14{i[15]}}, i[15:0], 2'b00};
    take = 1'b0;
    case (i[31:26])
      6'd2, 6'd3: return {pc[31:28], i[25:0], 2'b00};
      6'd4: take = (a == b);
      6'd5: take = (a != b);
      6'd6: take = ($signed(a) <= 0);
      6'd7: take = ($signed(a) > 0);
      6'd0: if (i[5:0] == 6'd8 || i[5:0] == 6'd9) return a;
      default: take = 1'b0;
    endcase
    return take ? pc + off : pc + 32'd4;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [31:0] i);
    case (i[31:26])
      6'd2, 6'd3: return "R3";
      6'd4, 6'd5: return "R5";
      6'd6, 6'd7: return "R6";
      6'd0: return (i[5:0] == 6'd8 || i[5:0] == 6'd9) ? "R7" : "R8";
      default: return "R8";
    endcase
  endfunction

  task automatic step(logic [31:0] i, logic [31:0] a, logic [31:0] b, logic st);
    logic ewe;
    logic [4:0] eidx;
    @(negedge clk);
    instr = i; rs_val = a; rt_val = b; stall = st;
    #1;
    eidx = (i[31:26] == 6'd3) ? 5'd31 : i[15:11];
    ewe = !st && (i[31:26] == 6'd3 || (i[31:26] == 6'd0 && i[5:0] == 6'd9)) && eidx != 5'd0;
    if (st) chk("R10 link_we", {31'd0, link_we}, 32'd0);
    else if (ewe) begin
      chk("R4/R7 link_we", {31'd0, link_we}, 32'd1);
      chk("R4/R7 link_idx", {27'd0, link_idx}, {27'd0, eidx});
      chk("R4/R7 link_val", link_val, mpc + 32'd4);
    end else chk("R9 link_we", {31'd0, link_we}, 32'd0);
    @(posedge clk);
    #1;
    if (st) chk("R10 hold", fetch_pc, mpc);
    else begin
      mpc = exp_next(i, a, b, mpc);
      chk(tag_of(i), fetch_pc, mpc);
    end
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom_range(0, 5))
      0: return 32'd0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", fetch_pc, RVEC);
    chk("R1 reset link", {31'd0, link_we}, 32'd0);
    instr = {6'd3, 26'h123}; rst_n = 1'b1; stall = 1'b1;
    @(posedge clk); #1;
    chk("R10 hold during boot", fetch_pc, RVEC);
    @(negedge clk); stall = 1'b0; #1;
    chk("R2 boot link", {31'd0, link_we}, 32'd0);
    @(posedge clk); #1;
    chk("R2 boot pc", fetch_pc, RVEC + 32'd4);
    mpc = RVEC + 32'd4;
    // directed corners
    step({6'd4, 5'd1, 5'd2, 16'h8000}, 32'd5, 32'd5, 1'b0);             // R5 min offset
    step({6'd5, 5'd1, 5'd2, 16'h7FFF}, 32'd5, 32'd6, 1'b0);             // R5 max offset
    step({6'd5, 5'd1, 5'd2, 16'h0010}, 32'd7, 32'd7, 1'b0);             // R8 not taken
    step({6'd7, 5'd1, 5'd0, 16'h0004}, 32'd0, 32'd0, 1'b0);             // R6 zero not >0
    step({6'd6, 5'd1, 5'd0, 16'hFFFC}, 32'h8000_0000, 32'd0, 1'b0);     // R6 most negative
    step({6'd7, 5'd1, 5'd0, 16'h0002}, 32'h7FFF_FFFF, 32'd0, 1'b0);     // R6 max positive
    step({6'd0, 5'd4, 15'd0, 6'd9}, 32'h0040_0000, 32'd0, 1'b0);        // R7 R9 rd=0 dropped
    step({6'd0, 5'd4, 5'd0, 5'd7, 5'd0, 6'd9}, 32'h1234_5678, 32'd0, 1'b0); // R7 rd=7
    step({6'd3, 26'h3FF_FFFF}, 32'd0, 32'd0, 1'b0);                     // R3 R4
    step({6'd2, 26'h000_0001}, 32'd0, 32'd0, 1'b1);                     // R10 stalled jump
    step({6'd0, 5'd3, 15'd0, 6'd8}, 32'hA000_0100, 32'd0, 1'b0);        // R7 JR
    step({6'd2, 26'h000_0040}, 32'd0, 32'd0, 1'b0);                     // R3 new region
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] i, a, b;
      logic [5:0] op;
      case ($urandom_range(0, 9))
        0: op = 6'd0;
        1: op = 6'd2;
        2: op = 6'd3;
        3: op = 6'd4;
        4: op = 6'd5;
        5: op = 6'd6;
        6: op = 6'd7;
        default: op = 6'($urandom_range(1, 63));
      endcase
      i = {op, 26'($urandom())};
      if (op == 6'd0 && $urandom_range(0, 1) == 1) i[5:0] = 6'(8 + $urandom_range(0, 1));
      a = pick32();
      b = ($urandom_range(0, 2) == 0) ? a : pick32();
      step(i, a, b, $urandom_range(0, 7) == 0);
    end
    finish_run();
  end
endmodule